// File: doc/BRIEF.md
# Selectable Cache Way Replacement Unit

This block keeps the lookup and eviction state for a single set of a small set-associative cache. For every way it stores a valid flag and a tag. Each access presents a tag. The unit decides whether the tag is already held, and reports either the matching way or the way chosen to receive the new line. On a miss it writes the new tag into that way in the same cycle.

A static select input chooses one of three eviction rules:
- oldest fill first (first-in-first-out);
- true least-recently-used, tracked as a per-way age rank;
- a not-recently-used approximation. It keeps one reference flag per way. The flag is set by any access to the way, and a periodic clear pulse wipes all the flags.

A running count of misses is kept. Data storage, set selection, write-back and coherence belong to the surrounding cache.

Top module: `way_repl_unit`

## Requirements
- R1: An access hits when its tag equals the stored tag of a valid way. The response then reports hit=1 and that way's index.
- R2: On a miss, if any way is invalid, the lowest-numbered invalid way is reported and filled, under every policy.
- R3: With policy code 0 (and the unused code 3, which acts the same), a miss in a full set evicts the way filled earliest. Hits do not change this order.
- R4: With policy code 1, a miss in a full set evicts the way whose latest access (hit or fill) is oldest.
- R5: With policy code 2, each access sets the reference flag of the accessed way. A miss in a full set evicts the lowest-numbered way whose flag is clear, or way 0 if every flag is set.
- R6: A clear pulse clears every reference flag. When it coincides with an access, the clear is applied first: the victim is chosen from the cleared flags, and the accessed way's flag ends set.
- R7: The response outputs are registered. rsp_valid is 1 exactly in the cycle after an access strobe and 0 otherwise. hit and way belong to that access.
- R8: miss_count rises by one for each miss and wraps modulo 2^CNT_W. Hits and idle cycles leave it unchanged.
- R9: After reset every way is invalid, rsp_valid is 0 and miss_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| acc_valid | input | 1 | Access strobe |
| acc_tag | input | TAG_W | Tag of the access |
| policy | input | 2 | Eviction rule: 0 FIFO, 1 LRU, 2 not-recently-used, 3 as 0 |
| ref_clr | input | 1 | Periodic pulse clearing all reference flags |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_way | output | $clog2(WAYS) | Matched way on a hit, filled way on a miss |
| miss_count | output | CNT_W | Running miss count |

## Verification
The bound checker watches the following on every cycle:
- a response appears exactly one cycle after each strobe and at no other time;
- the miss count moves only on a reported miss, and then by exactly one;
- the reported way always carries a set reference flag;
- a lone clear pulse leaves all flags at zero.

Victim choice under each policy can only be shown by the bench's scenarios. The bench drives long pseudo-random streams of a few tags, with idle cycles and clear pulses mixed in, through a four-way instance under every policy code. It compares each response against a timestamp model of fills and uses that is kept in the bench.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_FIFO = 2'd0,
    POL_LRU  = 2'd1,
    POL_NRU  = 2'd2,
    POL_RSVD = 2'd3
  } pol_e;
endpackage

// File: rtl/repl_tag_match.sv
module repl_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  // Scan from the top down so the lowest index wins.
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int i = WAYS-1; i >= 0; i--) begin
      if (valid_i[i] && (tags_i[i] == tag_i)) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(i);
      end
      if (!valid_i[i]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/repl_age_rank.sv
module repl_age_rank #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAY_W-1:0] oldest_o
);
  localparam logic [WAY_W-1:0] MAX_AGE = WAY_W'(WAYS-1);

  logic [WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAY_W-1:0]           touched_age;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < WAYS; i++)
      if (way_i == WAY_W'(i)) touched_age = age_q[i];
  end

  // The touched way becomes youngest; ways younger than it age by one.
  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (way_i == WAY_W'(i))          age_d[i] = '0;
        else if (age_q[i] < touched_age) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < WAYS; i++)
      if (age_q[i] == MAX_AGE) oldest_o = WAY_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_i) begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/repl_ref_bits.sv
module repl_ref_bits #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAYS-1:0]  bits_o,
  output logic [WAY_W-1:0] pick_o
);
  logic [WAYS-1:0] bits_q, bits_d, seen;

  // The clear is applied before victim selection and before the set.
  assign seen = clr_i ? '0 : bits_q;

  always_comb begin
    bits_d = seen;
    if (set_i) begin
      for (int i = 0; i < WAYS; i++)
        if (way_i == WAY_W'(i)) bits_d[i] = 1'b1;
    end
  end

  always_comb begin
    pick_o = '0;
    for (int i = WAYS-1; i >= 0; i--)
      if (!seen[i]) pick_o = WAY_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bits_q <= '0;
    else if (clr_i || set_i)   bits_q <= bits_d;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/way_repl_unit.sv
module way_repl_unit
  import repl_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [1:0]       policy,
  input  logic             ref_clr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [CNT_W-1:0] miss_count
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [WAYS-1:0]            valid_q, valid_d;
  logic [WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic                       hit, free;
  logic [WAY_W-1:0]           hit_way, free_way;
  logic [WAY_W-1:0]           fifo_old, lru_old, nru_pick, victim, acc_way;
  logic [WAYS-1:0]            ref_bits;
  logic                       fill;
  pol_e                       pol;

  assign pol = pol_e'(policy);

  repl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
    .valid_i(valid_q), .tags_i(tag_q), .tag_i(acc_tag),
    .hit_o(hit), .hit_way_o(hit_way), .free_o(free), .free_way_o(free_way)
  );

  assign fill = acc_valid && !hit;

  repl_age_rank #(.WAYS(WAYS), .WAY_W(WAY_W)) fifo_rank_i (
    .clk(clk), .rst_n(srst_n), .touch_i(fill), .way_i(acc_way), .oldest_o(fifo_old)
  );

  repl_age_rank #(.WAYS(WAYS), .WAY_W(WAY_W)) lru_rank_i (
    .clk(clk), .rst_n(srst_n), .touch_i(acc_valid), .way_i(acc_way), .oldest_o(lru_old)
  );

  repl_ref_bits #(.WAYS(WAYS), .WAY_W(WAY_W)) ref_i (
    .clk(clk), .rst_n(srst_n), .clr_i(ref_clr), .set_i(acc_valid),
    .way_i(acc_way), .bits_o(ref_bits), .pick_o(nru_pick)
  );

  always_comb begin
    unique case (pol)
      POL_LRU: victim = lru_old;
      POL_NRU: victim = nru_pick;
      default: victim = fifo_old;
    endcase
  end

  always_comb begin
    if (hit)       acc_way = hit_way;
    else if (free) acc_way = free_way;
    else           acc_way = victim;
  end

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    for (int i = 0; i < WAYS; i++) begin
      if (fill && (acc_way == WAY_W'(i))) begin
        valid_d[i] = 1'b1;
        tag_d[i]   = acc_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (fill) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_hit <= hit;
        rsp_way <= acc_way;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   miss_count <= '0;
    else if (fill) miss_count <= miss_count + 1'b1;
  end
endmodule

// File: rtl/way_repl_chk.sv
module way_repl_chk #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             srst_n,
  input logic             acc_valid,
  input logic             ref_clr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic [CNT_W-1:0] miss_count,
  input logic [WAYS-1:0]  ref_bits
);
  a_r7_rsp_after_strobe: assert property (@(posedge clk) disable iff (!srst_n)
    acc_valid |=> rsp_valid);

  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!srst_n)
    !acc_valid |=> !rsp_valid);

  a_r8_count_on_miss: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + 1'b1));

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!rsp_valid || rsp_hit) |-> $stable(miss_count));

  a_r5_ref_marked: assert property (@(posedge clk) disable iff (!srst_n)
    acc_valid |=> ref_bits[rsp_way]);

  a_r6_clear_all: assert property (@(posedge clk) disable iff (!srst_n)
    (ref_clr && !acc_valid) |=> (ref_bits == '0));

  a_r1_way_in_range: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |-> (int'(rsp_way) < WAYS));
endmodule

bind way_repl_unit way_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .srst_n(srst_n), .acc_valid(acc_valid), .ref_clr(ref_clr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
  .miss_count(miss_count), .ref_bits(ref_bits)
);

// File: tb/way_repl_unit_tb_top.sv
module way_repl_unit_tb_top;
  localparam int W  = 4;
  localparam int TW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [TW-1:0] acc_tag;
  logic [1:0]    policy;
  logic          ref_clr;
  logic          rsp_valid, rsp_hit;
  logic [1:0]    rsp_way;
  logic [CW-1:0] miss_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  way_repl_unit #(.WAYS(W), .TAG_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_tag(acc_tag),
    .policy(policy), .ref_clr(ref_clr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .miss_count(miss_count)
  );

  // Bench model: fill and use timestamps, reference flags, miss count.
  bit      m_valid [W];
  int      m_tag   [W];
  longint  m_fill  [W];
  longint  m_use   [W];
  bit      m_ref   [W];
  int      m_cnt;
  longint  now;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; ref_clr = 1'b0; acc_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_fill[i] = 0; m_use[i] = 0; m_ref[i] = 0;
    end
    m_cnt = 0; now = 1;
    check(rsp_valid == 1'b0, "R9 rsp_valid after reset", rsp_valid, 0);
    check(miss_count == '0, "R9 miss_count after reset", miss_count, 0);
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic step(input bit v, input int tag, input bit clr, input int pol);
    int  exp_way;
    bit  exp_hit;
    bit  any_free;
    string req;
    exp_hit = 0; exp_way = 0; any_free = 0; req = "R1";
    if (clr) for (int i = 0; i < W; i++) m_ref[i] = 0;
    if (v) begin
      for (int i = W-1; i >= 0; i--)
        if (m_valid[i] && m_tag[i] == tag) begin exp_hit = 1; exp_way = i; end
      if (!exp_hit) begin
        for (int i = W-1; i >= 0; i--)
          if (!m_valid[i]) begin any_free = 1; exp_way = i; end
        if (any_free) req = "R2";
        else if (pol == 1) begin
          req = "R4";
          exp_way = 0;
          for (int i = 1; i < W; i++) if (m_use[i] < m_use[exp_way]) exp_way = i;
        end else if (pol == 2) begin
          req = clr ? "R6" : "R5";
          exp_way = 0;
          for (int i = W-1; i >= 0; i--) if (!m_ref[i]) exp_way = i;
        end else begin
          req = "R3";
          exp_way = 0;
          for (int i = 1; i < W; i++) if (m_fill[i] < m_fill[exp_way]) exp_way = i;
        end
      end
    end
    acc_valid = v; acc_tag = TW'(tag); ref_clr = clr; policy = 2'(pol);
    @(negedge clk);
    acc_valid = 1'b0; ref_clr = 1'b0;
    check(rsp_valid == v, "R7 rsp_valid timing", rsp_valid, v);
    if (v) begin
      check(rsp_hit == exp_hit, {req, " hit flag"}, rsp_hit, exp_hit);
      check(int'(rsp_way) == exp_way, {req, " way"}, rsp_way, exp_way);
      if (!exp_hit) begin
        m_valid[exp_way] = 1; m_tag[exp_way] = tag; m_fill[exp_way] = now;
        m_cnt = (m_cnt + 1) % (1 << CW);
      end
      m_use[exp_way] = now;
      m_ref[exp_way] = 1;
      now++;
    end
    check(int'(miss_count) == m_cnt, "R8 miss count", miss_count, m_cnt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int s;
    policy = 2'd0;
    for (int p = 0; p < 4; p++) begin
      do_reset();
      // Directed: fill all ways in order (R2), then hit each (R1).
      for (int t = 0; t < W; t++) step(1, t + 8, 0, p);
      for (int t = W-1; t >= 0; t--) step(1, t + 8, 0, p);
      step(1, 15, 0, p);
      step(0, 0, 1, p);
      step(1, 14, 1, p);
      // Pseudo-random stream over six tags with idles and clears.
      s = 17 + p;
      for (int n = 0; n < 3000; n++) begin
        s = (s * 1103515245 + 12345) & 32'h7fffffff;
        step(((s >> 4) % 4) != 0, (s >> 8) % 6, ((s >> 12) % 9) == 0, p);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule